// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each data beat of one memory burst. A burst is launched by a start strobe. The strobe carries a starting column address, a burst-length code and an ordering select. The block then issues one column address per clock cycle until the burst is complete. Every address stays inside the aligned block of 2, 4 or 8 columns that holds the starting column. The bits above that block are copied unchanged from the start address. Only the low offset bits move.

Two beat orders are supported. In the sequential order the offset counts up from the starting offset and wraps at the block size. In the interleaved order the offset is the starting offset XORed with the beat number. A controller samples `ready_o`, pulses `start_i`, and uses the addresses while `col_valid_o` is high. `col_last_o` marks the final beat of the burst.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is active and in the first cycles after it, `ready_o` is 1 and `col_valid_o`, `col_last_o` and `blen_err_o` are 0.
- R2: A start is accepted at a rising edge where `start_i` and `ready_o` are both 1. Beat 0 appears in the cycle after that edge. One beat follows per cycle, and `col_valid_o` stays high for exactly BL cycles.
- R3: The burst-length code `blen_i` selects the burst length: 3'b001 selects BL 2, 3'b010 selects BL 4 and 3'b011 selects BL 8. Column bits from bit log2(BL) upward form the block number, and the bits below it are the starting offset.
- R4: When `order_i` is 0 (sequential), beat k carries the low offset (start + k) mod BL.
- R5: When `order_i` is 1 (interleaved), beat k carries the low offset start XOR k.
- R6: The offset wraps inside the aligned block. Every column bit from log2(BL) upward equals the start address on every beat of a burst.
- R7: `col_last_o` is high on beat BL−1 only. `ready_o` returns to 1 in the cycle after the last beat.
- R8: While a burst is in progress `ready_o` is 0, and a start strobe has no effect. No extra beats follow the burst.
- R9: The start address, burst-length code and order are captured at acceptance. Changing them during a burst does not alter that burst.
- R10: Any other `blen_i` code (3'b000 or 3'b100 to 3'b111) runs as BL 8. In that case `blen_err_o` is high for exactly one cycle, together with beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Burst start strobe |
| start_col_i | input | COL_W | Starting column address |
| blen_i | input | 3 | Burst-length code |
| order_i | input | 1 | Beat order: 0 sequential, 1 interleaved |
| ready_o | output | 1 | Block idle and able to accept a start |
| col_o | output | COL_W | Column address of the current beat |
| col_valid_o | output | 1 | `col_o` carries a beat |
| col_last_o | output | 1 | Current beat is the last of the burst |
| blen_err_o | output | 1 | One-cycle flag for an illegal burst-length code |

## Verification
Beat k of a burst is due k+1 cycles after the accepting edge. The error flag is due together with beat 0. `ready_o` is due one cycle after the last beat, which is BL+1 cycles after acceptance. The bench drives every input on the falling edge. It compares outputs on the next falling edge, which is the middle of the cycle each registered result belongs to. It walks the beats one falling edge at a time against a model computed from the start offset, so a result that arrives a cycle early or late fails the compare. The bench also changes mode inputs and pulses start in the middle of a burst. It then checks that the rest of the burst is unchanged and that nothing is issued after the last beat.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // widest burst is 8 beats, so three offset bits
  localparam int OFFS_W = 3;

  localparam logic [2:0] BLEN_CODE_2 = 3'b001;
  localparam logic [2:0] BLEN_CODE_4 = 3'b010;
  localparam logic [2:0] BLEN_CODE_8 = 3'b011;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_XOR = 1'b1
  } order_e;

  typedef struct packed {
    logic [OFFS_W-1:0] mask;   // BL-1
    order_e            order;
  } mode_t;
endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode
  import bcs_pkg::*;
(
  input  logic [2:0] blen_code_i,
  input  logic       order_i,
  output mode_t      mode_o,
  output logic       illegal_o
);

  always_comb begin
    mode_o.order = order_e'(order_i);
    illegal_o    = 1'b0;
    case (blen_code_i)
      BLEN_CODE_2: mode_o.mask = 3'b001;
      BLEN_CODE_4: mode_o.mask = 3'b011;
      BLEN_CODE_8: mode_o.mask = 3'b111;
      default: begin
        // R10: unknown codes fall back to the longest burst
        mode_o.mask = 3'b111;
        illegal_o   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bcs_beat_gen.sv
module bcs_beat_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0]  base_col_i,
  input  mode_t             mode_i,
  input  logic [OFFS_W-1:0] beat_i,
  output logic [COL_W-1:0]  col_o
);

  logic [OFFS_W-1:0] start_offs;
  logic [OFFS_W-1:0] seq_offs;
  logic [OFFS_W-1:0] xor_offs;
  logic [OFFS_W-1:0] pick_offs;

  assign start_offs = base_col_i[OFFS_W-1:0];
  assign seq_offs   = start_offs + beat_i;   // R4
  assign xor_offs   = start_offs ^ beat_i;   // R5

  always_comb begin
    pick_offs = (mode_i.order == ORDER_XOR) ? xor_offs : seq_offs;
  end

  // R6: per-bit merge, moving bits only below the block boundary
  generate
    for (genvar b = 0; b < OFFS_W; b++) begin : g_low
      assign col_o[b] = mode_i.mask[b] ? pick_offs[b] : base_col_i[b];
    end
  endgenerate

  assign col_o[COL_W-1:OFFS_W] = base_col_i[COL_W-1:OFFS_W];

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  mode_t             mode_i,
  input  logic              illegal_i,
  output logic              busy_o,
  output logic              last_o,
  output logic              err_o,
  output logic [COL_W-1:0]  base_col_o,
  output mode_t             mode_q_o,
  output logic [OFFS_W-1:0] beat_o
);

  logic              busy_q, busy_d;
  logic [OFFS_W-1:0] beat_q, beat_d;
  logic              err_q, err_d;
  mode_t             mode_q;
  logic [COL_W-1:0]  base_q;
  logic              accept;
  logic              last;

  assign accept = start_i & ~busy_q;                  // R8
  assign last   = busy_q & (beat_q == mode_q.mask);   // R7

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    if (accept) begin
      busy_d = 1'b1;
      beat_d = '0;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      beat_d = beat_q + 1'b1;
    end
    err_d = accept & illegal_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      err_q  <= err_d;
    end
  end

  // R9: burst parameters load only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      base_q <= '0;
    end else if (accept) begin
      mode_q <= mode_i;
      base_q <= start_col_i;
    end
  end

  assign busy_o     = busy_q;
  assign last_o     = last;
  assign err_o      = err_q;
  assign base_col_o = base_q;
  assign mode_q_o   = mode_q;
  assign beat_o     = beat_q;

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_q && beat_q == '0); // R2
  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last |=> busy_q); // R8
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last |=> $stable(mode_q) && $stable(base_q)); // R9
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q); // R10

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             order_i,
  output logic             ready_o,
  output logic [COL_W-1:0] col_o,
  output logic             col_valid_o,
  output logic             col_last_o,
  output logic             blen_err_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mode_t             dec_mode;
  logic              dec_illegal;
  mode_t             run_mode;
  logic [COL_W-1:0]  run_base;
  logic [OFFS_W-1:0] run_beat;
  logic              busy;
  logic              last;
  logic              err;

  bcs_mode_decode i_decode (
    .blen_code_i (blen_i),
    .order_i     (order_i),
    .mode_o      (dec_mode),
    .illegal_o   (dec_illegal)
  );

  bcs_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mode_i      (dec_mode),
    .illegal_i   (dec_illegal),
    .busy_o      (busy),
    .last_o      (last),
    .err_o       (err),
    .base_col_o  (run_base),
    .mode_q_o    (run_mode),
    .beat_o      (run_beat)
  );

  bcs_beat_gen #(.COL_W(COL_W)) i_beat (
    .base_col_i (run_base),
    .mode_i     (run_mode),
    .beat_i     (run_beat),
    .col_o      (col_o)
  );

  assign ready_o     = ~busy;
  assign col_valid_o = busy;
  assign col_last_o  = last;
  assign blen_err_o  = err;

  AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    col_valid_o && !col_last_o |=> col_o[COL_W-1:OFFS_W] == $past(col_o[COL_W-1:OFFS_W])); // R6
  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_sync_q)
    col_last_o |-> col_valid_o && !ready_o); // R7

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       blen_i;
  logic             order_i;
  logic             ready_o;
  logic [COL_W-1:0] col_o;
  logic             col_valid_o;
  logic             col_last_o;
  logic             blen_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .order_i(order_i), .ready_o(ready_o), .col_o(col_o),
    .col_valid_o(col_valid_o), .col_last_o(col_last_o), .blen_err_o(blen_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int beats_of(input logic [2:0] code);
    if (code == 3'b001) return 2;
    if (code == 3'b010) return 4;
    return 8;
  endfunction

  function automatic int model_col(input int start, input int bl, input bit xr, input int k);
    int s = start % bl;
    int offs = xr ? (s ^ k) : ((s + k) % bl);
    return (start - s) + offs;
  endfunction

  // one burst; optional disturbance of inputs while it runs (R8, R9)
  task automatic run_burst(input string name, input int start, input logic [2:0] code,
                           input bit xr, input bit disturb);
    int  bl  = beats_of(code);
    bit  bad = !(code inside {3'b001, 3'b010, 3'b011});
    @(negedge clk);
    check({name, " R2 ready before start"}, int'(ready_o), 1);
    start_i = 1'b1; start_col_i = COL_W'(start); blen_i = code; order_i = xr;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < bl; k++) begin
      check({name, " R2 valid"}, int'(col_valid_o), 1);
      check({name, xr ? " R5/R6 col" : " R4/R6 col"}, int'(col_o), model_col(start, bl, xr, k));
      check({name, " R7 last"}, int'(col_last_o), int'(k == bl - 1));
      check({name, " R10 err"}, int'(blen_err_o), int'(bad && k == 0));
      check({name, " R8 ready low"}, int'(ready_o), 0);
      if (disturb) begin
        start_i = 1'b1; start_col_i = ~COL_W'(start); blen_i = 3'b001; order_i = ~xr;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check({name, " R7 ready back"}, int'(ready_o), 1);
    check({name, " R8 no extra beat"}, int'(col_valid_o), 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; blen_i = 3'b011; order_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(ready_o), 1);
    check("R1 valid in reset", int'(col_valid_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ready after reset", int'(ready_o), 1);
    check("R1 valid after reset", int'(col_valid_o), 0);
    check("R1 last after reset", int'(col_last_o), 0);
    check("R1 err after reset", int'(blen_err_o), 0);
  endtask

  initial begin
    test_reset();
    run_burst("seq8 s5", 10'h2A5, 3'b011, 1'b0, 1'b0);   // R3 R4
    run_burst("xor8 s5", 10'h2A5, 3'b011, 1'b1, 1'b0);   // R5
    run_burst("seq4 s3", 10'h133, 3'b010, 1'b0, 1'b0);
    run_burst("xor4 s2", 10'h3FE, 3'b010, 1'b1, 1'b0);
    run_burst("seq2 s1", 10'h001, 3'b001, 1'b0, 1'b0);
    run_burst("xor2 s1", 10'h3FF, 3'b001, 1'b1, 1'b0);
    run_burst("seq8 s7 top", 10'h3FF, 3'b011, 1'b0, 1'b0); // R6 wrap at top
    run_burst("bad000", 10'h0C6, 3'b000, 1'b0, 1'b0);    // R10
    run_burst("bad111", 10'h153, 3'b111, 1'b1, 1'b0);    // R10
    run_burst("dist seq4", 10'h21D, 3'b010, 1'b0, 1'b1); // R8 R9
    run_burst("dist xor8", 10'h0EB, 3'b011, 1'b1, 1'b1); // R8 R9
    run_burst("b2b", 10'h0EB, 3'b011, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule